// File: doc/BRIEF.md
# Battery-Backed Byte-Wide Static RAM with Supply-Fault Protection

This block is the device side of a nonvolatile byte-wide static RAM, rebuilt as synchronous logic on a fast system clock. Three active-low strobes (select, write and output enable), the address and the data bus are sampled asynchronously. Two flip-flops bring each into the clock domain, and all decoding works on those synchronized copies. A write commits one byte when its write window closes. A read drives the data bus through a separate drive-enable output, so the tri-state pad is built outside the block.

A two-bit supply-status input stands in for the voltage monitor. While it reports anything other than the normal level, the strobes are ignored, no byte can be written and the data bus is released. The storage array has no reset and is never cleared, so its contents survive every supply state.

The strobes are level controls, not a stream. The block has no valid/ready handshake and cannot apply back-pressure. The host must hold the address and data stable for a few clock cycles around each strobe edge, as a host does for an asynchronous SRAM. Full depth is `ADDR_W = 13`. The default parameter is smaller to keep elaboration light.

Top module: `bbram_core`

## Requirements
- R1: A write window is open only while both the select and write strobes are low under normal supply. It opens at the later falling strobe and closes at the earlier rising strobe. Each window commits exactly one byte.
- R2: The committed byte and address are the bus values last sampled while the window was still open, not the values at the window's opening.
- R3: `data_oe_o` is high only while select and output enable are low and the write strobe is high. `data_o` then carries the byte stored at the sampled address.
- R4: If the write strobe falls while the bus is being driven, `data_oe_o` drops. Once the write strobe rises again with select still low, the bus is driven again and shows the newly written byte.
- R5: If the write strobe is already low when select falls, or falls in the same sample, `data_oe_o` stays low until select rises, even if the write strobe rises first.
- R6: Supply status encoding is 2'b00 = normal, 2'b01 = write-protect, 2'b10 = backup, 2'b11 = backup. In any non-normal state `data_oe_o` is low, and strobe activity writes nothing.
- R7: A write window that is open when the supply leaves normal is discarded, and the addressed byte keeps its previous value.
- R8: Stored bytes survive the backup state. After the supply returns to normal, a new window can open only after select or the write strobe has been seen high.
- R9: After reset, `data_oe_o` is low and `data_o` is zero.
- R10: `data_o` is zero whenever `data_oe_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset of the control logic (not the array) |
| supply_i | input | 2 | Supply status: 00 normal, 01 write-protect, 1x backup |
| sel_n_i | input | 1 | Active-low chip select |
| wr_n_i | input | 1 | Active-low write strobe |
| rd_en_n_i | input | 1 | Active-low output enable |
| addr_i | input | ADDR_W | Byte address |
| data_i | input | DATA_W | Data bus as seen by the device (pad input) |
| data_o | output | DATA_W | Read data toward the pad, zero when not driving |
| data_oe_o | output | 1 | Pad drive enable |

## Verification
Writes are issued in two strobe orders. In the write-strobe-controlled order, select falls first and the write strobe ends the window. In the select-controlled order, the write strobe falls first and select ends the window. Together the two orders separate a correct AND-window from one keyed to a single strobe. A window in which the data bus changes before it closes shows whether the last or the first sample is committed. Reads with the write strobe falling during a driven read, and with the write strobe already low before select, separate the turn-off-then-resume behaviour from the hold-off-for-the-whole-cycle behaviour. Write attempts under write-protect and under backup, a window cut short by a fault, and strobes held low across recovery check that the stored bytes and the bus drive are untouched.

// File: rtl/bbram_pkg.sv
package bbram_pkg;
  timeunit 1ns;
  timeprecision 100ps;

  typedef enum logic [1:0] {
    SUP_NORMAL  = 2'b00,
    SUP_PROTECT = 2'b01,
    SUP_BACKUP  = 2'b10,
    SUP_BACKUP2 = 2'b11
  } supply_e;

  function automatic logic supply_is_normal(input logic [1:0] s);
    return s == SUP_NORMAL;
  endfunction
endpackage

// File: rtl/bbram_sync.sv
module bbram_sync #(
  parameter int               W       = 1,
  parameter int               STAGES  = 2,
  parameter logic [W-1:0]     RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  timeunit 1ns;
  timeprecision 100ps;

  logic [W-1:0] stg [STAGES];

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[0] <= RST_VAL;
          else        stg[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[i] <= RST_VAL;
          else        stg[i] <= stg[i-1];
        end
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/bbram_array.sv
module bbram_array #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  timeunit 1ns;
  timeprecision 100ps;

  localparam int DEPTH = 1 << ADDR_W;

  // No reset: the contents persist across every supply state.
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/bbram_cycle_ctl.sv
module bbram_cycle_ctl #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sup_ok,
  input  logic              ce_s,
  input  logic              we_s,
  input  logic              oe_s,
  input  logic [ADDR_W-1:0] addr_s,
  input  logic [DATA_W-1:0] data_s,
  output logic              mem_we,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              drive_q
);
  timeunit 1ns;
  timeprecision 100ps;

  logic armed;
  logic win_q;
  logic ce_prev;
  logic hide_q;
  logic win_now;
  logic ce_fall;

  // Window requires both strobes low, a normal supply, and a re-arm after faults.
  assign win_now = sup_ok && armed && !ce_s && !we_s;
  assign ce_fall = ce_prev && !ce_s;
  // Close by a rising strobe commits; close by a fault does not.
  assign mem_we  = win_q && sup_ok && (ce_s || we_s);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed   <= 1'b0;
      win_q   <= 1'b0;
      ce_prev <= 1'b1;
      hide_q  <= 1'b0;
      drive_q <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      if (!sup_ok)            armed <= 1'b0;
      else if (ce_s || we_s)  armed <= 1'b1;

      win_q   <= win_now;
      ce_prev <= ce_s;

      if (win_now) begin
        wr_addr <= addr_s;
        wr_data <= data_s;
      end

      if (ce_s)                  hide_q <= 1'b0;
      else if (ce_fall && !we_s) hide_q <= 1'b1;

      drive_q <= sup_ok && !ce_s && !oe_s && we_s && !hide_q;
    end
  end
endmodule

// File: rtl/bbram_core.sv
module bbram_core #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        supply_i,
  input  logic              sel_n_i,
  input  logic              wr_n_i,
  input  logic              rd_en_n_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o
);
  timeunit 1ns;
  timeprecision 100ps;
  import bbram_pkg::*;

  localparam int BUS_W = ADDR_W + DATA_W;

  logic [2:0]        str_s;
  logic [1:0]        sup_s;
  logic [BUS_W-1:0]  bus_s;
  logic              ce_s, we_s, oe_s, sup_ok;
  logic [ADDR_W-1:0] addr_s;
  logic [DATA_W-1:0] data_s;
  logic              mem_we;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;
  logic [DATA_W-1:0] rd_data;
  logic              drive_q;

  bbram_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b111)) u_str_sync (
    .clk(clk), .rst_n(rst_n), .d({rd_en_n_i, wr_n_i, sel_n_i}), .q(str_s)
  );

  bbram_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b10)) u_sup_sync (
    .clk(clk), .rst_n(rst_n), .d(supply_i), .q(sup_s)
  );

  bbram_sync #(.W(BUS_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_bus_sync (
    .clk(clk), .rst_n(rst_n), .d({addr_i, data_i}), .q(bus_s)
  );

  assign ce_s   = str_s[0];
  assign we_s   = str_s[1];
  assign oe_s   = str_s[2];
  assign sup_ok = supply_is_normal(sup_s);
  assign addr_s = bus_s[BUS_W-1:DATA_W];
  assign data_s = bus_s[DATA_W-1:0];

  bbram_cycle_ctl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .sup_ok(sup_ok),
    .ce_s(ce_s), .we_s(we_s), .oe_s(oe_s),
    .addr_s(addr_s), .data_s(data_s),
    .mem_we(mem_we), .wr_addr(wr_addr), .wr_data(wr_data),
    .drive_q(drive_q)
  );

  bbram_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk(clk), .wr_en(mem_we), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(addr_s), .rd_data(rd_data)
  );

  assign data_oe_o = drive_q;
  assign data_o    = drive_q ? rd_data : '0;
endmodule

// File: rtl/bbram_checker.sv
module bbram_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sup_ok,
  input logic              ce_s,
  input logic              we_s,
  input logic              oe_s,
  input logic              mem_we,
  input logic              data_oe_o,
  input logic [DATA_W-1:0] data_o
);
  timeunit 1ns;
  timeprecision 100ps;

  p_hiz_on_fault_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !sup_ok |=> !data_oe_o);

  p_no_write_on_fault_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> $past(sup_ok));

  p_read_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_oe_o) |-> $past(!ce_s && !oe_s && we_s));

  p_quiet_bus_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !data_oe_o |-> data_o == '0);

  p_one_commit_r1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we);

  p_write_hides_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !we_s |=> !data_oe_o);
endmodule

bind bbram_core bbram_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sup_ok(sup_ok), .ce_s(ce_s), .we_s(we_s),
  .oe_s(oe_s), .mem_we(mem_we), .data_oe_o(data_oe_o), .data_o(data_o)
);

// File: tb/bbram_core_bench.sv
module bbram_core_bench;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int ADDR_W = 11;
  localparam int DATA_W = 8;
  localparam int SETTLE = 6;
  localparam logic [ADDR_W-1:0] TOP_A = '1;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [1:0]        supply = 2'b00;
  logic              sel_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] din = '0;
  logic [DATA_W-1:0] dout;
  logic              doe;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  logic [DATA_W:0] exp_q [$];
  string           tag_q [$];

  always #2.5 clk = ~clk;

  bbram_core #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bbram_core (
    .clk(clk), .rst_n(rst_n), .supply_i(supply),
    .sel_n_i(sel_n), .wr_n_i(wr_n), .rd_en_n_i(rd_n),
    .addr_i(addr), .data_i(din), .data_o(dout), .data_oe_o(doe)
  );

  // Monitor: sample 1 ns after each rising edge, compare against the queue.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        logic [DATA_W:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        n_tests++;
        if ({doe, dout} !== e) begin
          n_fail++;
          $display("FAIL %s: actual oe=%0b data=%02h, expected oe=%0b data=%02h",
                   t, doe, dout, e[DATA_W], e[DATA_W-1:0]);
        end
      end
    end
  end

  task automatic settle();
    repeat (SETTLE) @(negedge clk);
  endtask

  task automatic pins(input logic s, input logic w, input logic r);
    @(negedge clk);
    sel_n = s; wr_n = w; rd_n = r;
    settle();
  endtask

  task automatic expect_bus(input logic oe, input logic [DATA_W-1:0] d, input string t);
    @(negedge clk);
    exp_q.push_back({oe, d});
    tag_q.push_back(t);
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic set_bus(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    @(negedge clk);
    addr = a; din = d;
    settle();
  endtask

  task automatic set_supply(input logic [1:0] s);
    @(negedge clk);
    supply = s;
    settle();
  endtask

  // Write ended by the write strobe (select falls first).
  task automatic write_we(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    set_bus(a, d);
    pins(0, 1, 1);
    pins(0, 0, 1);
    pins(0, 1, 1);
    pins(1, 1, 1);
  endtask

  // Write ended by select (write strobe falls first).
  task automatic write_ce(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    set_bus(a, d);
    pins(1, 0, 1);
    pins(0, 0, 1);
    pins(1, 0, 1);
    pins(1, 1, 1);
  endtask

  task automatic read_chk(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d, input string t);
    set_bus(a, din);
    pins(0, 1, 0);
    expect_bus(1'b1, d, t);
    pins(1, 1, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    expect_bus(1'b0, 8'h00, "R9 reset state");
    rst_n = 1'b1;
    settle();
    expect_bus(1'b0, 8'h00, "R9 idle after reset");

    // R1: both strobe orders
    write_we(11'd5, 8'h3C);
    read_chk(11'd5, 8'h3C, "R1 write-strobe-ended window");
    write_ce(11'd0, 8'hC3);
    read_chk(11'd0, 8'hC3, "R1 select-ended window");
    read_chk(11'd5, 8'h3C, "R1 neighbour untouched");

    // R2: data changes inside the window, last sample is committed
    set_bus(TOP_A, 8'h11);
    pins(0, 1, 1);
    pins(0, 0, 1);
    set_bus(TOP_A, 8'h77);
    pins(0, 1, 1);
    pins(1, 1, 1);
    read_chk(TOP_A, 8'h77, "R2 last in-window sample at top address");

    // R3 / R4: write strobe falls during a driven read
    write_we(11'd9, 8'hA5);
    set_bus(11'd9, 8'h5A);
    pins(0, 1, 0);
    expect_bus(1'b1, 8'hA5, "R3 driven read");
    pins(0, 0, 0);
    expect_bus(1'b0, 8'h00, "R4 drive drops on write strobe");
    pins(0, 1, 0);
    expect_bus(1'b1, 8'h5A, "R4 drive resumes with new byte");
    pins(1, 1, 1);

    // R5: write strobe low before select falls
    pins(1, 0, 0);
    pins(0, 0, 0);
    expect_bus(1'b0, 8'h00, "R5 hidden while both low");
    pins(0, 1, 0);
    expect_bus(1'b0, 8'h00, "R5 stays hidden after write strobe rises");
    pins(1, 1, 1);

    // R10: output enable alone does not drive
    pins(1, 1, 0);
    expect_bus(1'b0, 8'h00, "R10 quiet bus without select");
    pins(1, 1, 1);

    // R6: write-protect
    set_supply(2'b01);
    set_bus(11'd9, 8'h00);
    pins(0, 1, 0);
    expect_bus(1'b0, 8'h00, "R6 no drive under protect");
    pins(0, 0, 1);
    pins(0, 1, 1);
    pins(1, 1, 1);
    set_supply(2'b00);
    read_chk(11'd9, 8'h5A, "R6 write ignored under protect");

    // R7: window cut short by backup
    set_bus(11'd9, 8'h99);
    pins(0, 0, 1);
    set_supply(2'b10);
    pins(0, 1, 1);
    pins(1, 1, 1);
    set_supply(2'b00);
    read_chk(11'd9, 8'h5A, "R7 interrupted window discarded");

    // R8: strobes held low across recovery, contents survive
    set_supply(2'b11);
    set_bus(11'd5, 8'hEE);
    pins(0, 0, 1);
    set_supply(2'b00);
    pins(1, 0, 1);
    pins(1, 1, 1);
    read_chk(11'd5, 8'h3C, "R8 no write without re-arm");
    read_chk(11'd0, 8'hC3, "R8 byte survives backup");
    read_chk(TOP_A, 8'h77, "R8 top byte survives backup");

    repeat (4) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual running, expected finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule